// File: doc/BRIEF.md
# Accumulator Carry and Shift Unit

This unit performs the single-operand accumulator instructions and the carry-flag instructions of an 8-bit processor datapath. It takes the current accumulator and the carry (C) and half-carry (HC) flags, together with an operation code and a flag that says whether the most recent arithmetic was a subtraction. One clock edge later it presents the updated accumulator and flags.

The operations are clear, increment, decrement, rotate right through carry, rotate left through carry, nibble exchange, set carry, clear carry, and decimal adjustment after a BCD add or subtract. For decimal adjustment, C and HC follow a carry-out convention after an add: 1 means a carry left the byte or the low digit. After a subtract they follow a no-borrow convention: 1 means no borrow occurred. Codes that are not assigned to an operation pass the inputs through unchanged. The main adder and the memory path are not part of this unit.

Top module: `acs_unit`

## Requirements
- R1: While rst_n is low, acc_o, c_o and hc_o are all 0.
- R2: Every result appears on the outputs on the first rising clock edge after the inputs are sampled, so the latency is exactly one cycle.
- R3: Clear (op_i = 0) writes 0x00 to the accumulator and keeps C and HC equal to c_i and hc_i.
- R4: Increment (op_i = 1) and decrement (op_i = 2) add or subtract 1 modulo 256, so 0xFF increments to 0x00 and 0x00 decrements to 0xFF. C and HC are kept.
- R5: Rotate right through carry (op_i = 3) produces {c_i, acc_i[7:1]}, sets C to acc_i[0] and keeps HC.
- R6: Rotate left through carry (op_i = 4) produces {acc_i[6:0], c_i}, sets C to acc_i[7] and sets HC to acc_i[0].
- R7: Nibble swap (op_i = 5) produces {acc_i[3:0], acc_i[7:4]} and keeps C and HC.
- R8: Set carry (op_i = 6) drives both C and HC to 1. Clear carry (op_i = 7) drives both to 0. Both keep the accumulator.
- R9: Decimal adjust (op_i = 8) with sub_i = 0 adds 0x06 when hc_i = 1 or acc_i[3:0] > 9. It also adds 0x60 when c_i = 1 or acc_i[7:4] > 9. The sum wraps modulo 256, and C and HC are kept.
- R10: Decimal adjust (op_i = 8) with sub_i = 1 subtracts 0x06 when hc_i = 0 and subtracts 0x60 when c_i = 0. The result wraps modulo 256, and C and HC are kept.
- R11: Codes 9 to 15 pass acc_i, c_i and hc_i through unchanged. sub_i has no effect on any code other than 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| c_i | input | 1 | Current carry flag |
| hc_i | input | 1 | Current half-carry flag |
| sub_i | input | 1 | 1 when the last arithmetic operation was a subtract |
| acc_o | output | 8 | Updated accumulator, registered |
| c_o | output | 1 | Updated carry flag, registered |
| hc_o | output | 1 | Updated half-carry flag, registered |

## Verification
The hardest case is decimal adjustment. Its two digit corrections depend on a combination of flag values, nibble ranges and the add/subtract direction. Uniform random bytes seldom hit the boundary where a nibble is exactly 9 or 10 while both flags are clear. The stimulus therefore adds directed cases at the nibble boundaries for both directions and biases random decimal-adjust operands toward them. It also changes sub_i on every operation, so that any leak of the subtract flag into the other operations shows up at the outputs.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int ACC_W = 8;
    localparam int NIB_W = 4;
    localparam int OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CLR  = 4'd0,
        OP_INC  = 4'd1,
        OP_DEC  = 4'd2,
        OP_RRC  = 4'd3,
        OP_RLC  = 4'd4,
        OP_SWAP = 4'd5,
        OP_SETC = 4'd6,
        OP_CLRC = 4'd7,
        OP_DADJ = 4'd8
    } acs_op_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             c;
        logic             hc;
    } acs_state_t;
endpackage

// File: rtl/acs_shift.sv
module acs_shift
    import acs_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic             c_i,
    output logic [ACC_W-1:0] rr_acc_o,
    output logic             rr_c_o,
    output logic [ACC_W-1:0] rl_acc_o,
    output logic             rl_c_o,
    output logic             rl_hc_o,
    output logic [ACC_W-1:0] swap_o
);
    localparam int HALF = ACC_W / 2;

    always_comb begin
        rr_acc_o = {c_i, acc_i[ACC_W-1:1]};
        rr_c_o   = acc_i[0];
        rl_acc_o = {acc_i[ACC_W-2:0], c_i};
        rl_c_o   = acc_i[ACC_W-1];
        rl_hc_o  = acc_i[0];
        swap_o   = {acc_i[HALF-1:0], acc_i[ACC_W-1:HALF]};
    end
endmodule

// File: rtl/acs_decadj.sv
module acs_decadj
    import acs_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic             c_i,
    input  logic             hc_i,
    input  logic             sub_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int NDIG = ACC_W / NIB_W;

    logic [NDIG-1:0]  dig_flag;
    logic [NDIG-1:0]  dig_fix;
    logic [ACC_W-1:0] adj;

    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        if (k == 0) begin : g_low
            assign dig_flag[k] = hc_i;
        end else begin : g_high
            assign dig_flag[k] = c_i;
        end
        assign dig_fix[k] = sub_i ? ~dig_flag[k]
                                  : (dig_flag[k] | (acc_i[k*NIB_W +: NIB_W] > 4'd9));
        assign adj[k*NIB_W +: NIB_W] = dig_fix[k] ? 4'h6 : 4'h0;
    end

    always_comb begin
        acc_o = sub_i ? (acc_i - adj) : (acc_i + adj);
    end
endmodule

// File: rtl/acs_unit.sv
module acs_unit
    import acs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             c_i,
    input  logic             hc_i,
    input  logic             sub_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             c_o,
    output logic             hc_o
);
    acs_state_t state_d, state_q;

    logic [ACC_W-1:0] rr_acc, rl_acc, swap_acc, dadj_acc;
    logic             rr_c, rl_c, rl_hc;

    acs_shift u_shift (
        .acc_i    (acc_i),
        .c_i      (c_i),
        .rr_acc_o (rr_acc),
        .rr_c_o   (rr_c),
        .rl_acc_o (rl_acc),
        .rl_c_o   (rl_c),
        .rl_hc_o  (rl_hc),
        .swap_o   (swap_acc)
    );

    acs_decadj u_decadj (
        .acc_i (acc_i),
        .c_i   (c_i),
        .hc_i  (hc_i),
        .sub_i (sub_i),
        .acc_o (dadj_acc)
    );

    always_comb begin
        state_d.acc = acc_i;
        state_d.c   = c_i;
        state_d.hc  = hc_i;
        case (op_i)
            OP_CLR:  state_d.acc = '0;
            OP_INC:  state_d.acc = acc_i + 1'b1;
            OP_DEC:  state_d.acc = acc_i - 1'b1;
            OP_RRC: begin
                state_d.acc = rr_acc;
                state_d.c   = rr_c;
            end
            OP_RLC: begin
                state_d.acc = rl_acc;
                state_d.c   = rl_c;
                state_d.hc  = rl_hc;
            end
            OP_SWAP: state_d.acc = swap_acc;
            OP_SETC: begin
                state_d.c  = 1'b1;
                state_d.hc = 1'b1;
            end
            OP_CLRC: begin
                state_d.c  = 1'b0;
                state_d.hc = 1'b0;
            end
            OP_DADJ: state_d.acc = dadj_acc;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign acc_o = state_q.acc;
    assign c_o   = state_q.c;
    assign hc_o  = state_q.hc;
endmodule

// File: rtl/acs_unit_chk.sv
module acs_unit_chk
    import acs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [ACC_W-1:0] acc_i,
    input logic             c_i,
    input logic             hc_i,
    input logic             sub_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             c_o,
    input logic             hc_o
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (acc_o == '0 && !c_o && !hc_o));

    // R3
    clear_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_CLR) |-> (acc_o == '0 && c_o == $past(c_i) && hc_o == $past(hc_i)));

    // R5
    rrc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_RRC) |-> (c_o == $past(acc_i[0]) && acc_o[7] == $past(c_i)));

    // R6
    rlc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_RLC) |-> (c_o == $past(acc_i[7]) && hc_o == $past(acc_i[0]) && acc_o[0] == $past(c_i)));

    // R8
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_SETC) |-> (c_o && hc_o && acc_o == $past(acc_i)));

    // R8
    clr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_CLRC) |-> (!c_o && !hc_o && acc_o == $past(acc_i)));

    // R7
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_SWAP) |-> (acc_o[3:0] == $past(acc_i[7:4]) && acc_o[7:4] == $past(acc_i[3:0])));

    // R11
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) > 4'd8) |-> (acc_o == $past(acc_i) && c_o == $past(c_i) && hc_o == $past(hc_i)));
endmodule

bind acs_unit acs_unit_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .acc_i (acc_i),
    .c_i   (c_i),
    .hc_i  (hc_i),
    .sub_i (sub_i),
    .acc_o (acc_o),
    .c_o   (c_o),
    .hc_o  (hc_o)
);

// File: tb/acs_unit_tb.sv
module acs_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic       c_i = 1'b0;
    logic       hc_i = 1'b0;
    logic       sub_i = 1'b0;
    logic [7:0] acc_o;
    logic       c_o, hc_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    acs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
        .c_i(c_i), .hc_i(hc_i), .sub_i(sub_i),
        .acc_o(acc_o), .c_o(c_o), .hc_o(hc_o)
    );

    function automatic logic [9:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic c, input logic hc, input logic sb);
        logic [7:0] r;
        logic       rc, rh;
        logic [7:0] fix;
        r = a; rc = c; rh = hc;
        case (op)
            4'd0: r = 8'h00;
            4'd1: r = a + 8'd1;
            4'd2: r = a - 8'd1;
            4'd3: begin r = {c, a[7:1]}; rc = a[0]; end
            4'd4: begin r = {a[6:0], c}; rc = a[7]; rh = a[0]; end
            4'd5: r = {a[3:0], a[7:4]};
            4'd6: begin rc = 1'b1; rh = 1'b1; end
            4'd7: begin rc = 1'b0; rh = 1'b0; end
            4'd8: begin
                fix = 8'h00;
                if (!sb) begin
                    if (hc || a[3:0] > 4'd9) fix = fix + 8'h06;
                    if (c  || a[7:4] > 4'd9) fix = fix + 8'h60;
                    r = a + fix;
                end else begin
                    if (!hc) fix = fix + 8'h06;
                    if (!c)  fix = fix + 8'h60;
                    r = a - fix;
                end
            end
            default: ;
        endcase
        return {r, rc, rh};
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic sb);
        case (op)
            4'd0: return "R3";
            4'd1, 4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8: return sb ? "R10" : "R9";
            default: return "R11";
        endcase
    endfunction

    // R2: drive at a falling edge, check at the next falling edge (one rising edge later)
    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic c, input logic hc, input logic sb);
        logic [9:0] exp;
        @(negedge clk);
        op_i = op; acc_i = a; c_i = c; hc_i = hc; sub_i = sb;
        exp = model(op, a, c, hc, sb);
        @(negedge clk);
        total++;
        if ({acc_o, c_o, hc_o} !== exp) begin
            bad++;
            $display("FAIL %s (R2 timing) op=%0d acc_in=%h c=%b hc=%b sub=%b got acc=%h c=%b hc=%b exp acc=%h c=%b hc=%b",
                     req_of(op, sb), op, a, c, hc, sb, acc_o, c_o, hc_o, exp[9:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        op_i = 4'd4; acc_i = 8'hA5; c_i = 1'b1; hc_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if ({acc_o, c_o, hc_o} !== 10'd0) begin
            bad++;
            $display("FAIL R1 reset got acc=%h c=%b hc=%b exp acc=00 c=0 hc=0", acc_o, c_o, hc_o);
        end
        rst_n = 1'b1;

        // directed corners
        run_op(4'd0, 8'h5A, 1'b1, 1'b0, 1'b1);   // R3
        run_op(4'd1, 8'hFF, 1'b0, 1'b1, 1'b0);   // R4 wrap up
        run_op(4'd2, 8'h00, 1'b1, 1'b0, 1'b1);   // R4 wrap down
        run_op(4'd3, 8'h01, 1'b1, 1'b0, 1'b0);   // R5
        run_op(4'd4, 8'h81, 1'b0, 1'b0, 1'b0);   // R6
        run_op(4'd4, 8'h7E, 1'b1, 1'b1, 1'b1);   // R6
        run_op(4'd5, 8'h3C, 1'b1, 1'b0, 1'b0);   // R7
        run_op(4'd6, 8'h11, 1'b0, 1'b0, 1'b0);   // R8
        run_op(4'd7, 8'h22, 1'b1, 1'b1, 1'b1);   // R8
        run_op(4'd8, 8'h9A, 1'b0, 1'b0, 1'b0);   // R9 low digit above 9
        run_op(4'd8, 8'hA9, 1'b0, 1'b0, 1'b0);   // R9 high digit above 9
        run_op(4'd8, 8'h99, 1'b0, 1'b0, 1'b0);   // R9 no fix
        run_op(4'd8, 8'h12, 1'b1, 1'b1, 1'b0);   // R9 both flags
        run_op(4'd8, 8'h99, 1'b1, 1'b1, 1'b1);   // R10 no borrow
        run_op(4'd8, 8'h0F, 1'b0, 1'b0, 1'b1);   // R10 both borrows
        run_op(4'd8, 8'h00, 1'b1, 1'b0, 1'b1);   // R10 wrap
        run_op(4'd12, 8'hC3, 1'b1, 1'b0, 1'b1);  // R11
        run_op(4'd15, 8'h3C, 1'b0, 1'b1, 1'b0);  // R11

        // random mix, decimal adjust biased to digit boundaries
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            logic [7:0] a;
            op = 4'($urandom_range(0, 15));
            a  = 8'($urandom);
            if (op == 4'd8 && $urandom_range(0, 1) == 1)
                a = {4'($urandom_range(8, 11)), 4'($urandom_range(8, 11))};
            run_op(op, a, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule